// File: doc/BRIEF.md
# Millisecond Watchdog and Event Status Registers

This block is a small byte-wide register slave on a plain host register bus: an 8-bit address, a write strobe, a read strobe and 8-bit data in each direction. It contains a 16-bit payload watchdog and an event status register.

Software sets the watchdog limit in milliseconds through two threshold bytes. A clock divider, sized by a parameter, turns the system clock into a millisecond tick. A millisecond counter advances on each tick. When the counter reaches the limit, the block raises a one-clock expiry pulse and starts counting again from zero. Writing either threshold byte restarts both the divider and the counter, so a threshold write also serves as a service ("kick") operation. A limit of zero turns the watchdog off.

The event status register watches two external flags, an expiry flag and an early-warning flag. A status bit is latched only on the 0-to-1 transition of its flag. Software clears a bit by writing a 1 to it.

Top module: `ms_watchdog_regs`

## Requirements
- R1: After reset the threshold low byte (address 0x1A) reads 0xFF, the threshold high byte (address 0x1B) reads 0x00 and the status register (address 0x19) reads 0x00.
- R2: When the 16-bit threshold {high, low} is zero, the watchdog is disabled: wd_bite never asserts and the counters are held at zero.
- R3: Any write to address 0x1A or 0x1B restarts the tick divider and the millisecond counter from zero.
- R4: With threshold T nonzero, wd_bite is high for exactly one clock, T*CLKS_PER_MS clock edges after the last threshold write or the last expiry. Counting then restarts, so the pulses repeat with that period.
- R5: The threshold bytes at 0x1A (bits 7:0 of the threshold) and 0x1B (bits 15:8) are readable and writable, and each keeps the last value written.
- R6: Status bit 0 sets when ev_timeout_in goes from 0 to 1, and status bit 1 sets when ev_pretimeout_in goes from 0 to 1. A flag that stays high does not set its bit again.
- R7: Writing to 0x19 clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R8: If a rising edge of a flag and a write-1-to-clear of the same bit occur in the same cycle, the bit ends up set.
- R9: Status bits 7:2 always read as zero, and writes to them have no effect.
- R10: bus_rdata is combinational. It shows the addressed register while bus_rd is high, and is zero when bus_rd is low or the address is not mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up / cold reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ev_timeout_in | input | 1 | External expiry flag |
| ev_pretimeout_in | input | 1 | External early-warning flag |
| wd_bite | output | 1 | One-clock watchdog expiry pulse |

## Verification
The watchdog is tried with several patterns. Small thresholds are run for two periods, which separates an exact T*CLKS_PER_MS period from an off-by-one period or from a pulse that does not repeat. A threshold is rewritten partway through a count, which shows whether the write really restarts the count or only updates the compare value. A zero threshold is held over a long window, which exposes any expiry leaking through while disabled. The status register is tried with a flag that stays high across a clear, with a rising edge in the same cycle as a clear, and with partial clear masks, which separates edge capture from level capture and shows that set takes priority over clear.

// File: rtl/ms_watchdog_regs.sv
module ms_watchdog_regs #(
  parameter int CLKS_PER_MS = 100000,
  parameter int THR_W       = 16,
  parameter logic [7:0] A_STAT   = 8'h19,
  parameter logic [7:0] A_THR_LO = 8'h1A,
  parameter logic [7:0] A_THR_HI = 8'h1B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ev_timeout_in,
  input  logic       ev_pretimeout_in,
  output logic       wd_bite
);
  localparam int DIV_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_MS - 1);

  logic [THR_W-1:0] thr_q, ms_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [1:0]       ev_prev, ev_stat;

  wire wr_stat = bus_wr && (bus_addr == A_STAT);
  wire wr_lo   = bus_wr && (bus_addr == A_THR_LO);
  wire wr_hi   = bus_wr && (bus_addr == A_THR_HI);
  wire kick    = wr_lo || wr_hi;
  wire wd_off  = (thr_q == '0);
  wire ms_tick = (div_cnt == DIV_LAST);
  wire expire  = ms_tick && (ms_cnt + 1'b1 == thr_q);
  wire [1:0] ev_now  = {ev_pretimeout_in, ev_timeout_in};
  wire [1:0] ev_rise = ev_now & ~ev_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_W'(16'h00FF);
    end else begin
      if (wr_lo) thr_q[7:0]  <= bus_wdata;
      if (wr_hi) thr_q[15:8] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      ms_cnt  <= '0;
      wd_bite <= 1'b0;
    end else if (kick || wd_off) begin
      div_cnt <= '0;
      ms_cnt  <= '0;
      wd_bite <= 1'b0;
    end else begin
      div_cnt <= ms_tick ? '0 : div_cnt + 1'b1;
      wd_bite <= expire;
      if (expire)       ms_cnt <= '0;
      else if (ms_tick) ms_cnt <= ms_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_prev <= '0;
      ev_stat <= '0;
    end else begin
      ev_prev <= ev_now;
      ev_stat <= (ev_stat & ~(wr_stat ? bus_wdata[1:0] : 2'b00)) | ev_rise;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        A_STAT:   bus_rdata = {6'b0, ev_stat};
        A_THR_LO: bus_rdata = thr_q[7:0];
        A_THR_HI: bus_rdata = thr_q[15:8];
        default:  bus_rdata = 8'h00;
      endcase
    end
  end

  initial assert (CLKS_PER_MS >= 2 && THR_W == 16);

  p_no_bite_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |=> !wd_bite);
  p_kick_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (ms_cnt == '0 && div_cnt == '0 && !wd_bite));
  p_bite_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |=> !wd_bite);
  p_bite_cnt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |-> (ms_cnt == '0));
  p_rise_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise[0] |=> ev_stat[0]);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise[1] && wr_stat && bus_wdata[1]) |=> ev_stat[1]);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !ev_rise[0]) |=> !ev_stat[0]);
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STAT) |-> (bus_rdata[7:2] == 6'b0));
  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

// File: tb/ms_watchdog_regs_tb.sv
module ms_watchdog_regs_tb;
  localparam int CPM = 4;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic wr = 0, rd = 0, ev_to = 0, ev_pre = 0, bite;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ms_watchdog_regs #(.CLKS_PER_MS(CPM)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .ev_timeout_in(ev_to),
    .ev_pretimeout_in(ev_pre), .wd_bite(bite));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(8'h1A, d); check("R1 lo", d, 8'hFF);
    rd_reg(8'h1B, d); check("R1 hi", d, 8'h00);
    rd_reg(8'h19, d); check("R1 stat", d, 8'h00);
    #1 check("R10 idle", rdata, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr_reg(8'h1B, 8'hA5); wr_reg(8'h1A, 8'h3C);
    rd_reg(8'h1B, d); check("R5 hi", d, 8'hA5);
    rd_reg(8'h1A, d); check("R5 lo", d, 8'h3C);
    rd_reg(8'h42, d); check("R10 unmapped", d, 8'h00);
  endtask

  task automatic t_period(int t);
    int hits = 0;
    wr_reg(8'h1B, 8'h00); wr_reg(8'h1A, t[7:0]);
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < t*CPM - 1; i++) begin
        @(negedge clk); if (bite) hits++;
      end
      check("R4 early", {7'b0, hits != 0}, 8'h00);
      @(negedge clk); check("R4 pulse", {7'b0, bite}, 8'h01);
    end
  endtask

  task automatic t_disable;
    int hits = 0;
    wr_reg(8'h1B, 8'h00); wr_reg(8'h1A, 8'h00);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); if (bite) hits++;
    end
    check("R2 disabled", hits[7:0], 8'h00);
  endtask

  task automatic t_restart;
    int hits = 0;
    wr_reg(8'h1A, 8'h03);
    repeat (8) @(negedge clk);
    wr_reg(8'h1B, 8'h00);
    for (int i = 0; i < 3*CPM - 1; i++) begin
      @(negedge clk); if (bite) hits++;
    end
    check("R3 no early bite", hits[7:0], 8'h00);
    @(negedge clk); check("R3 bite after restart", {7'b0, bite}, 8'h01);
  endtask

  task automatic t_status;
    logic [7:0] d;
    @(negedge clk); ev_to = 1;
    rd_reg(8'h19, d); check("R6 timeout edge", d, 8'h01);
    wr_reg(8'h19, 8'h01);
    rd_reg(8'h19, d); check("R6 level no reset", d, 8'h00);
    @(negedge clk); ev_pre = 1; ev_to = 0;
    rd_reg(8'h19, d); check("R6 pre edge", d, 8'h02);
    @(negedge clk); ev_to = 1;
    wr_reg(8'h19, 8'h01);
    rd_reg(8'h19, d); check("R7 partial clear", d, 8'h02);
    wr_reg(8'h19, 8'hFC);
    rd_reg(8'h19, d); check("R9 reserved/R7 zero mask", d, 8'h02);
    wr_reg(8'h19, 8'h02);
    rd_reg(8'h19, d); check("R7 clear", d, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] d;
    @(negedge clk); ev_to = 0; ev_pre = 0;
    @(negedge clk); addr = 8'h19; wdata = 8'h03; wr = 1; ev_to = 1;
    @(negedge clk); wr = 0;
    rd_reg(8'h19, d); check("R8 set wins", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_period(1);
    t_period(3);
    t_disable();
    t_restart();
    t_status();
    t_set_wins();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule